// File: doc/BRIEF.md
# Addressed Serial Step-Attenuator Control Receiver

This block takes a three-wire serial control stream (data, shift clock, latch strobe) and turns it into a held 7-bit attenuation code for a step attenuator, plus the eighth bit of the received attenuation byte. Every device on a shared three-wire bus sees every frame. A device only takes the new setting when the low three bits of the address byte in the frame match its own strap pins. All three serial wires are asynchronous to the block's system clock. Each one is brought in through a two-flop synchronizer, and the block acts on the edges it detects after synchronization.

A frame is 16 bits, sent least significant bit first. The attenuation byte is sent first and the address byte last. Each code step is a quarter decibel, so the code equals four times the wanted attenuation in dB. For example, 18.25 dB is code 73. The receiver fills its shift register while the latch line is low. A rising edge on the latch line tests the address and, on a hit, moves the attenuation byte into the output register. Out of reset the output holds the full-scale code 0x7F, which is the safe, maximum-attenuation state.

The outputs are level signals held between updates, so they take no back-pressure. The `update_o` strobe is a one-cycle flag with no ready signal; a consumer that needs the value reads the held code at any time.

Top module: `atten_serial_rx`

## Requirements
- R1: After reset, `atten_code_o` is 0x7F, `code_msb_o` is 0 and `update_o` is 0.
- R2: Frame bits are taken in least significant bit first. The first 8 bits shifted form the attenuation byte (bits 0..6 form the code, bit 7 is the extra bit). The next 8 bits form the address byte.
- R3: Only address-byte bits 0..2 (frame bits 8..10) are compared with `addr_pins_i`. Address-byte bits 3..7 have no effect on the match.
- R4: On a latch rising edge with an address mismatch, `atten_code_o` and `code_msb_o` keep their values and `update_o` stays low.
- R5: Shift-clock rising edges that occur while the latch line is high do not shift data.
- R6: The outputs change only on a latch rising edge with an address match. They hold steady while a frame is being shifted in.
- R7: `code_msb_o` shows bit 7 of the latched attenuation byte.
- R8: `update_o` pulses high for exactly one system clock when a matching latch changes the held value. It stays low when a matching latch reloads the same value.
- R9: If more than 16 shift edges arrive before a latch, only the last 16 bits shifted are kept.
- R10: The new value appears on the outputs three system clock rising edges after the latch pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_latch_i | input | 1 | Latch strobe, asynchronous; low while shifting |
| addr_pins_i | input | 3 | Static device address straps |
| atten_code_o | output | 7 | Held attenuation code, 0.25 dB per LSB |
| code_msb_o | output | 1 | Held bit 7 of the attenuation byte |
| update_o | output | 1 | One-cycle pulse when the held value changes |

## Verification
The hardest case to reach is a shift-clock edge that arrives while the latch line is high. Such an edge leaves no trace in the outputs unless a later latch exposes what the shift register holds. The stimulus therefore loads a valid frame, keeps the latch high, and toggles sixteen all-ones bits into the shift clock. Because the straps are set to address 7, those bits would form a matching full-scale frame if they were taken. A second latch then has to reload the original value with no update pulse. The stimulus also gets over-long frames by sending junk bits ahead of a valid frame, and it measures latency by raising the latch pin on a falling clock edge and sampling after each rising edge.

// File: rtl/atten_rx_pkg.sv
package atten_rx_pkg;
  // Geometry of one control frame
  localparam int unsigned WORD_W  = 8;
  localparam int unsigned FRAME_W = 2 * WORD_W;
  localparam int unsigned CODE_W  = WORD_W - 1;

  typedef struct packed {
    logic              msb;
    logic [CODE_W-1:0] code;
  } atten_word_t;

  function automatic atten_word_t split_word(input logic [WORD_W-1:0] b);
    atten_word_t w;
    w.msb  = b[WORD_W-1];
    w.code = b[CODE_W-1:0];
    return w;
  endfunction
endpackage

// File: rtl/atten_rx_sync.sv
module atten_rx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[STAGES-1];

  assign level_o = stg[STAGES-1];
  assign rise_o  = stg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/atten_rx_shifter.sv
module atten_rx_shifter #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame_o
);
  // New bits enter at the top, so the first bit ends at position 0.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        frame_o <= '0;
    else if (shift_en) frame_o <= {bit_in, frame_o[FRAME_W-1:1]};
endmodule

// File: rtl/atten_rx_hold.sv
module atten_rx_hold
  import atten_rx_pkg::*;
#(
  parameter int unsigned PIN_W      = 3,
  parameter logic [CODE_W-1:0] RESET_CODE = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [PIN_W-1:0]   pins_i,
  output atten_word_t        word_o,
  output logic               update_o,
  output logic               hit_o
);
  atten_word_t incoming;

  assign hit_o    = (frame_i[WORD_W +: PIN_W] == pins_i);
  assign incoming = split_word(frame_i[WORD_W-1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word_o   <= '{msb: 1'b0, code: RESET_CODE};
      update_o <= 1'b0;
    end else begin
      update_o <= 1'b0;
      if (load_i && hit_o) begin
        word_o   <= incoming;
        update_o <= (incoming != word_o);
      end
    end
endmodule

// File: rtl/atten_serial_rx.sv
module atten_serial_rx
  import atten_rx_pkg::*;
#(
  parameter int unsigned PIN_W     = 3,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data_i,
  input  logic              ser_clk_i,
  input  logic              ser_latch_i,
  input  logic [PIN_W-1:0]  addr_pins_i,
  output logic [CODE_W-1:0] atten_code_o,
  output logic              code_msb_o,
  output logic              update_o
);
  localparam int unsigned N_SYNC = 3;
  localparam int unsigned IX_DAT = 0;
  localparam int unsigned IX_CLK = 1;
  localparam int unsigned IX_LAT = 2;

  logic [N_SYNC-1:0]  sync_lvl, sync_rise;
  logic               sclk_rise, lat_lvl, lat_rise, shift_en, addr_hit;
  logic [FRAME_W-1:0] frame_q;
  atten_word_t        held;

  atten_rx_sync #(.W(N_SYNC), .STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_latch_i, ser_clk_i, ser_data_i}),
    .level_o (sync_lvl),
    .rise_o  (sync_rise)
  );

  assign sclk_rise = sync_rise[IX_CLK];
  assign lat_lvl   = sync_lvl[IX_LAT];
  assign lat_rise  = sync_rise[IX_LAT];
  assign shift_en  = sclk_rise & ~lat_lvl;

  atten_rx_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .bit_in   (sync_lvl[IX_DAT]),
    .frame_o  (frame_q)
  );

  atten_rx_hold #(.PIN_W(PIN_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (lat_rise),
    .frame_i  (frame_q),
    .pins_i   (addr_pins_i),
    .word_o   (held),
    .update_o (update_o),
    .hit_o    (addr_hit)
  );

  assign atten_code_o = held.code;
  assign code_msb_o   = held.msb;
endmodule

// File: rtl/atten_rx_checker.sv
module atten_rx_checker #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CODE_W  = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CODE_W-1:0]  code,
  input logic               msb,
  input logic               upd,
  input logic               lat_rise,
  input logic               lat_lvl,
  input logic               sclk_rise,
  input logic               addr_hit,
  input logic [FRAME_W-1:0] frame
);
  assert_reset_full_scale_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (code == '1 && !msb && !upd));

  assert_mismatch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && !addr_hit) |=> ($stable(code) && $stable(msb) && !upd));

  assert_frozen_when_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && lat_lvl) |=> $stable(frame));

  assert_hold_between_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_rise |=> ($stable(code) && $stable(msb)));

  assert_change_strobed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(code) || !$stable(msb)) |-> upd);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);
endmodule

bind atten_serial_rx atten_rx_checker #(.FRAME_W(16), .CODE_W(7)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .code      (atten_code_o),
  .msb       (code_msb_o),
  .upd       (update_o),
  .lat_rise  (lat_rise),
  .lat_lvl   (lat_lvl),
  .sclk_rise (sclk_rise),
  .addr_hit  (addr_hit),
  .frame     (frame_q)
);

// File: tb/test_atten_serial_rx.sv
module test_atten_serial_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0;
  logic [2:0] pins = 3'd3;
  logic [6:0] code;
  logic       msb, upd;

  int checks = 0, fails = 0, upd_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atten_serial_rx i_atten_serial_rx (
    .clk(clk), .rst_n(rst_n), .ser_data_i(ser_data), .ser_clk_i(ser_clk),
    .ser_latch_i(ser_latch), .addr_pins_i(pins), .atten_code_o(code),
    .code_msb_o(msb), .update_o(upd)
  );

  always @(negedge clk) if (rst_n && upd) upd_cnt++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      ser_data = bits[i];
      wait_clks(HALF_BIT);
      ser_clk = 1'b1;
      wait_clks(HALF_BIT);
      ser_clk = 1'b0;
    end
    wait_clks(HALF_BIT);
  endtask

  task automatic pulse_latch();
    ser_latch = 1'b1;
    wait_clks(HALF_BIT);
    ser_latch = 1'b0;
    wait_clks(HALF_BIT);
  endtask

  task automatic load(input logic [7:0] addr, input logic [7:0] att);
    send_bits({16'h0, addr, att}, 16);
    pulse_latch();
  endtask

  task automatic t_reset();
    check("R1 code", code, 7'h7F);
    check("R1 msb", msb, 0);
    check("R1 update", upd, 0);
  endtask

  task automatic t_match_example();
    upd_cnt = 0;
    pins = 3'd3;
    send_bits({16'h0, 8'b1111_1011, 8'd73}, 16);
    check("R6 hold during shift", code, 7'h7F);
    pulse_latch();
    check("R2 code 73", code, 73);
    check("R3 upper addr bits ignored", code, 73);
    check("R8 one strobe", upd_cnt, 1);
  endtask

  task automatic t_mismatch();
    upd_cnt = 0;
    load(8'h07, 8'd20);
    check("R4 code kept", code, 73);
    check("R4 no strobe", upd_cnt, 0);
    pins = 3'd6;
    load(8'h02, 8'd21);
    check("R3 bit2 differs", code, 73);
  endtask

  task automatic t_latency();
    pins = 3'd5;
    send_bits({16'h0, 8'h05, 8'd5}, 16);
    ser_latch = 1'b1;
    wait_clks(2);
    check("R10 old after two edges", code, 73);
    wait_clks(1);
    check("R10 new after three edges", code, 5);
    ser_latch = 1'b0;
    wait_clks(HALF_BIT);
  endtask

  task automatic t_ignore_while_high();
    pins = 3'd7;
    load(8'h07, 8'h11);
    check("R5 preload", code, 8'h11);
    upd_cnt = 0;
    ser_latch = 1'b1;
    wait_clks(HALF_BIT);
    send_bits(32'hFFFF_FFFF, 16);
    ser_latch = 1'b0;
    wait_clks(HALF_BIT);
    pulse_latch();
    check("R5 code unchanged", code, 8'h11);
    check("R8 reload same no strobe", upd_cnt, 0);
  endtask

  task automatic t_msb();
    pins = 3'd1;
    load(8'h01, 8'h8A);
    check("R7 code", code, 8'h0A);
    check("R7 msb", msb, 1);
    load(8'h01, 8'h00);
    check("R7 msb clear", msb, 0);
    check("R2 zero code", code, 0);
  endtask

  task automatic t_overlong();
    pins = 3'd2;
    upd_cnt = 0;
    send_bits({12'h0, 8'h02, 8'h7F, 4'b1010}, 20);
    pulse_latch();
    check("R9 last 16 kept", code, 7'h7F);
    check("R8 strobe on change", upd_cnt, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(2);
    t_reset();
    t_match_example();
    t_mismatch();
    t_latency();
    t_ignore_while_high();
    t_msb();
    t_overlong();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule